// File: doc/BRIEF.md
# Three-Phase Hall Commutation Logic

This block turns three digitized Hall sensor levels into six gate-drive enables for a three-phase brushless motor bridge. There is one high-side enable and one low-side enable for each of the phases U, V and W. For each legal rotor position it selects one high-side switch and one low-side switch. It reverses rotation by complementing the Hall word before it decodes it. It chops only the selected high-side switch with an externally generated PWM gate. The selected low-side switch stays fully on.

An external current comparator can cut the high-side switch short. Once tripped, that switch stays off until the next PWM period starts, which lowers the effective duty. The block also has three states that override normal drive. Short-circuit braking turns on all high-side switches at full duty. Stop and undervoltage turn every switch off. An undefined Hall code also turns every switch off.

The direction, stop and brake controls come from slow, possibly asynchronous sources, so each passes through a synchronizer first. Hall, PWM gate, current trip and undervoltage are taken as already synchronous to `clk`. Every output comes from a register. All pins are plain levels with no handshake.

Top module: `bldc_commutator`

## Requirements
- R1: Forward rotation is selected when the synchronized direction is 0. Hall word {hall_i[2],hall_i[1],hall_i[0]} selects outputs as follows: 101 gives V-high and U-low, 100 gives W-high and U-low, 110 gives W-high and V-low, 010 gives U-high and V-low, 011 gives U-high and W-low, 001 gives V-high and W-low. In both `hi_o` and `lo_o`, bit 0 is phase U, bit 1 is V and bit 2 is W.
- R2: Reverse rotation is selected when the synchronized direction is 1. The Hall word is bitwise inverted and then decoded with the table of R1.
- R3: The selected high-side bit follows `pwm_gate_i`. The selected low-side bit stays 1 while `pwm_gate_i` is 0.
- R4: Hall words 000 and 111 drive all six outputs to 0.
- R5: When the synchronized brake is 1 in the run state, `hi_o` = 111 and `lo_o` = 000, whatever the values of Hall, PWM and direction.
- R6: `ilim_trip_i` has no effect while braking. No trip seen during braking is carried past brake release.
- R7: Outside braking, `ilim_trip_i` = 1 forces the high-side output to 0 on the next clock. The high side stays 0, even after the trip drops, until a rising edge of `pwm_gate_i` starts a new period. It is then driven again on that edge's clock. The low side is not affected.
- R8: Reset gives all outputs 0, and the controls reset to stop, brake and reverse. A synchronized stop of 1 drives all outputs to 0 and overrides brake. Brake can be applied and released while in run.
- R9: `uv_fault_i` = 1 drives all outputs to 0 on the next clock and overrides every other input.
- R10: A change on `hall_i`, `pwm_gate_i`, `ilim_trip_i` or `uv_fault_i` reaches the outputs after 1 clock. A change on `stop_i`, `brake_i` or `dir_rev_i` reaches them after 3 clocks (two synchronizer stages plus the output register).
- R11: After a change of synchronized direction, all outputs are 0 for exactly one clock. The first decode in the new direction follows that clock, so a change of `dir_rev_i` shows as zeros 3 clocks later and as the new drive 4 clocks later.
- R12: No phase ever has its high-side and low-side outputs at 1 together, and at most one low-side output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Digitized Hall levels, bit 2 = sensor 1 |
| dir_rev_i | input | 1 | 1 = reverse, 0 = forward (synchronized) |
| stop_i | input | 1 | 1 = stop, 0 = run (synchronized) |
| brake_i | input | 1 | 1 = short-circuit brake (synchronized) |
| pwm_gate_i | input | 1 | PWM chop level; a rising edge starts a period |
| ilim_trip_i | input | 1 | Current-limit comparator trip |
| uv_fault_i | input | 1 | Supply undervoltage flag |
| hi_o | output | 3 | High-side enables, bit 0 = U, 1 = V, 2 = W |
| lo_o | output | 3 | Low-side enables, bit 0 = U, 1 = V, 2 = W |

## Verification
Results are due at different times depending on the input that changed. A Hall, PWM, trip or undervoltage change is due one clock after it is applied. A stop or brake change is due three clocks later. A direction change shows its blank clock three clocks later and the new drive four clocks later. The driver task applies each stimulus on a falling edge and waits the exact number of rising edges for that input class. Only then does it queue the expected output pair. The monitor compares the pair two time units after the same falling edge, so no check lands on an edge where the outputs are still moving. Separate checks one clock before the due time confirm that the synchronized controls are not early.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int NPHASE = 3;
  localparam int HALL_W = 3;

  typedef struct packed {
    logic [NPHASE-1:0] hi;
    logic [NPHASE-1:0] lo;
  } drive_t;

  localparam drive_t DRV_OFF   = '{hi: '0, lo: '0};
  localparam drive_t DRV_BRAKE = '{hi: '1, lo: '0};
endpackage

// File: rtl/cmt_sync.sv
module cmt_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cmt_decode.sv
module cmt_decode
  import cmt_pkg::*;
(
  input  logic [HALL_W-1:0] hall_i,
  input  logic              rev_i,
  output drive_t            sel_o,
  output logic              illegal_o
);
  logic [HALL_W-1:0] key;

  // Reverse rotation uses the inverted Hall word on the same table.
  assign key = rev_i ? ~hall_i : hall_i;

  always_comb begin
    sel_o     = DRV_OFF;
    illegal_o = 1'b0;
    unique case (key)
      3'b101: sel_o = '{hi: 3'b010, lo: 3'b001};
      3'b100: sel_o = '{hi: 3'b100, lo: 3'b001};
      3'b110: sel_o = '{hi: 3'b100, lo: 3'b010};
      3'b010: sel_o = '{hi: 3'b001, lo: 3'b010};
      3'b011: sel_o = '{hi: 3'b001, lo: 3'b100};
      3'b001: sel_o = '{hi: 3'b010, lo: 3'b100};
      default: illegal_o = 1'b1;
    endcase
  end

  // R12: a legal position selects exactly one high and one low switch on different phases.
  always_comb begin
    if (!illegal_o) begin
      p_one_pair_r12: assert ($countones(sel_o.hi) == 1 && $countones(sel_o.lo) == 1
                              && (sel_o.hi & sel_o.lo) == '0);
    end
  end
endmodule

// File: rtl/cmt_chop.sv
module cmt_chop (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic trip_i,
  input  logic hold_i,
  output logic gate_o
);
  logic pwm_q;
  logic trip_q;
  logic rise;

  assign rise   = pwm_i & ~pwm_q;
  // A trip blanks the high side until a new PWM period begins.
  assign gate_o = pwm_i & ~trip_i & ~(trip_q & ~rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q  <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      pwm_q <= pwm_i;
      if (hold_i)    trip_q <= 1'b0;
      else if (rise) trip_q <= trip_i;
      else           trip_q <= trip_q | trip_i;
    end
  end

  // R7: once latched, the trip survives until a rising edge of the PWM gate.
  p_trip_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !hold_i && !pwm_i) |=> trip_q);
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import cmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HALL_W-1:0]   hall_i,
  input  logic                dir_rev_i,
  input  logic                stop_i,
  input  logic                brake_i,
  input  logic                pwm_gate_i,
  input  logic                ilim_trip_i,
  input  logic                uv_fault_i,
  output logic [NPHASE-1:0]   hi_o,
  output logic [NPHASE-1:0]   lo_o
);
  localparam int NCTL = 3;

  logic [NCTL-1:0] ctl_s;
  logic            dir_s, stop_s, brake_s;
  logic            dir_q;
  logic            dir_chg;
  drive_t          sel;
  logic            illegal;
  logic            hi_gate;
  drive_t          drv_d, drv_q;

  // Reset state: reverse, stop, brake, the same as open control inputs.
  cmt_sync #(.WIDTH(NCTL), .STAGES(SYNC_STAGES), .RST_VAL({NCTL{1'b1}})) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({dir_rev_i, stop_i, brake_i}),
    .q_o   (ctl_s)
  );

  assign {dir_s, stop_s, brake_s} = ctl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b1;
    else        dir_q <= dir_s;
  end

  assign dir_chg = dir_s ^ dir_q;

  cmt_decode u_dec (
    .hall_i    (hall_i),
    .rev_i     (dir_s),
    .sel_o     (sel),
    .illegal_o (illegal)
  );

  cmt_chop u_chop (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_i  (pwm_gate_i),
    .trip_i (ilim_trip_i),
    .hold_i (brake_s),
    .gate_o (hi_gate)
  );

  always_comb begin
    if (uv_fault_i)     drv_d = DRV_OFF;
    else if (stop_s)    drv_d = DRV_OFF;
    else if (brake_s)   drv_d = DRV_BRAKE;
    else if (dir_chg)   drv_d = DRV_OFF;
    else if (illegal)   drv_d = DRV_OFF;
    else                drv_d = '{hi: sel.hi & {NPHASE{hi_gate}}, lo: sel.lo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= DRV_OFF;
    else        drv_q <= drv_d;
  end

  assign hi_o = drv_q.hi;
  assign lo_o = drv_q.lo;

  // R12: no shoot-through on any phase, and a single low-side switch at most.
  p_no_shoot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_o & lo_o) == '0) && $onehot0(lo_o));

  // R9: undervoltage blanks everything on the next clock.
  p_uv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault_i |=> (hi_o == '0 && lo_o == '0));

  // R5: braking in run drives all high sides at full duty.
  p_brake_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_s && !stop_s && !uv_fault_i) |=> (hi_o == '1 && lo_o == '0));

  // R8: stop blanks everything.
  p_stop_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_s |=> (hi_o == '0 && lo_o == '0));

  // R7: a trip outside braking removes high-side drive on the next clock.
  p_trip_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_trip_i && !brake_s) |=> (hi_o == '0));

  // R11: a direction change inserts one fully off clock.
  p_dir_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_chg && !brake_s) |=> (hi_o == '0 && lo_o == '0));
endmodule

// File: tb/sim_bldc_commutator.sv
module sim_bldc_commutator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b101;
  logic       dir = 1'b0, stp = 1'b0, brk = 1'b0, pwm = 1'b1, ilim = 1'b0, uv = 1'b0;
  logic [2:0] hi_o, lo_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] hi;
    logic [2:0] lo;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  bldc_commutator u0 (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .dir_rev_i(dir), .stop_i(stp),
    .brake_i(brk), .pwm_gate_i(pwm), .ilim_trip_i(ilim), .uv_fault_i(uv),
    .hi_o(hi_o), .lo_o(lo_o)
  );

  // Forward table from R1: {hi, lo}, bit 0 = U.
  function automatic logic [5:0] ref_fwd(input logic [2:0] h);
    case (h)
      3'b101: return {3'b010, 3'b001};
      3'b100: return {3'b100, 3'b001};
      3'b110: return {3'b100, 3'b010};
      3'b010: return {3'b001, 3'b010};
      3'b011: return {3'b001, 3'b100};
      3'b001: return {3'b010, 3'b100};
      default: return 6'b0;
    endcase
  endfunction

  task automatic put(input logic [2:0] h, input logic d, s, b, p, i, u);
    @(negedge clk);
    hall = h; dir = d; stp = s; brk = b; pwm = p; ilim = i; uv = u;
  endtask

  // Wait n rising edges after the stimulus, then queue the expected pair.
  task automatic want(input int n, input logic [5:0] e, input string tag);
    exp_t x;
    repeat (n) @(negedge clk);
    x.hi = e[5:3]; x.lo = e[2:0]; x.tag = tag;
    q.push_back(x);
  endtask

  // Monitor: compares away from the rising edge.
  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_chk++;
      if (hi_o !== x.hi || lo_o !== x.lo) begin
        n_bad++;
        $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", x.tag, hi_o, lo_o, x.hi, x.lo);
      end
      if ((hi_o & lo_o) != 3'b000) begin
        n_bad++;
        $display("FAIL R12: hi=%b lo=%b share a phase, expected disjoint", hi_o, lo_o);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    want(0, 6'b0, "R8 reset state");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 forward table, PWM high
    for (int k = 0; k < 8; k++) begin
      logic [2:0] h;
      h = 3'(k);
      put(h, 0, 0, 0, 1, 0, 0);
      want(1, ref_fwd(h), (k == 0 || k == 7) ? "R4 illegal hall" : "R1 forward decode");
    end
    // R3 PWM low: high side off, low side on
    put(3'b011, 0, 0, 0, 0, 0, 0);
    want(1, {3'b000, 3'b100}, "R3 chop low");
    put(3'b011, 0, 0, 0, 1, 0, 0);
    want(1, {3'b001, 3'b100}, "R3 chop high");

    // R11 direction change: blank at 3, new drive at 4
    put(3'b101, 0, 0, 0, 1, 0, 0);
    want(1, ref_fwd(3'b101), "R10 hall one clock");
    put(3'b101, 1, 0, 0, 1, 0, 0);
    want(2, ref_fwd(3'b101), "R10 dir not early");
    want(1, 6'b0, "R11 direction blank");
    want(1, ref_fwd(3'b010), "R11 reverse after blank");

    // R2 reverse table
    for (int k = 1; k < 7; k++) begin
      logic [2:0] h;
      h = 3'(k);
      put(h, 1, 0, 0, 1, 0, 0);
      want(1, ref_fwd(~h), "R2 reverse decode");
    end
    put(3'b111, 1, 0, 0, 1, 0, 0);
    want(1, 6'b0, "R4 illegal hall reverse");

    // back to forward
    put(3'b110, 0, 0, 0, 1, 0, 0);
    want(4, ref_fwd(3'b110), "R11 forward after blank");

    // R5 brake, R10 latency
    put(3'b110, 0, 0, 1, 0, 0, 0);
    want(2, {3'b000, 3'b010}, "R10 brake not early");
    want(1, {3'b111, 3'b000}, "R5 brake full duty");
    put(3'b000, 0, 0, 1, 0, 1, 0);
    want(1, {3'b111, 3'b000}, "R6 trip ignored in brake");
    put(3'b110, 0, 0, 0, 1, 0, 0);
    want(3, ref_fwd(3'b110), "R8 brake released in run");

    // R7 trip blanks until next PWM rise
    put(3'b110, 0, 0, 0, 1, 1, 0);
    want(1, {3'b000, 3'b010}, "R7 trip cut");
    put(3'b110, 0, 0, 0, 1, 0, 0);
    want(1, {3'b000, 3'b010}, "R7 trip held");
    put(3'b110, 0, 0, 0, 0, 0, 0);
    want(1, {3'b000, 3'b010}, "R7 low side kept");
    put(3'b110, 0, 0, 0, 1, 0, 0);
    want(1, {3'b100, 3'b010}, "R7 new period");

    // R8 stop overrides brake
    put(3'b110, 0, 1, 1, 1, 0, 0);
    want(3, 6'b0, "R8 stop off");
    put(3'b110, 0, 0, 1, 1, 0, 0);
    want(3, {3'b111, 3'b000}, "R8 run brake");

    // R9 undervoltage over brake
    put(3'b110, 0, 0, 1, 1, 0, 1);
    want(1, 6'b0, "R9 uv over brake");
    put(3'b110, 0, 0, 0, 1, 0, 1);
    want(3, 6'b0, "R9 uv over drive");
    put(3'b110, 0, 0, 0, 1, 0, 0);
    want(1, ref_fwd(3'b110), "R9 uv cleared");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule